// File: doc/BRIEF.md
# Self-Correcting Triple-Redundant Counter

This block is a modulo counter built as three identical copies, called domains, that run side by side. Each domain has its own clock, reset, advance, fault-injection and output pins. A domain never feeds its own state straight back into its next-state logic. It first passes all three current states through its own bitwise 2-of-3 majority voter. As a result, a domain whose register has been corrupted is brought back into line at the next rising edge, with no reset and no command.

Each domain drives its copy of the count onto its own output pins, together with an active-high pad drive enable. A per-domain dissent detector turns the enable off when the other two domains agree with each other and this domain holds a different value. The three pin groups are meant to be tied together on the board, so a dissenting domain floats its pads and the resolved value stays correct.

Each domain also keeps a sticky flag. The flag records that the domain's register once disagreed with the voted state, and it clears only on that domain's reset.

Top module: `tmr_counter`

## Requirements
- R1: While reset is asserted (active low), every domain's count is 0, every drive enable is 1 and every flag is 0.
- R2: On each rising edge with advance high and no injection, every domain's count becomes (voted count + STEP) taken modulo LIMIT.
- R3: When voted count + STEP reaches or exceeds LIMIT, the count wraps to voted count + STEP − LIMIT.
- R4: On a rising edge with advance low and no injection, the count keeps its voted value.
- R5: A domain forced by its injection strobe holds the injected value for exactly one cycle. At the next edge without injection it again equals the other two domains.
- R6: A domain's drive enable is 0 exactly when the other two counts are equal and its own count differs from them. Otherwise it is 1.
- R7: While at most one domain is faulty, the value resolved from all enabled pin groups equals the count of a single fault-free counter, and at least one group drives.
- R8: A domain's flag goes to 1 at the edge after its count differed from the voted count, and stays 1 from then on.
- R9: Injecting the value the domain would have loaded anyway disables no pin and sets no flag.
- R10: Asserting a domain's reset clears its flag and returns its count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | Clock of domain 0 |
| clk1 | input | 1 | Clock of domain 1 |
| clk2 | input | 1 | Clock of domain 2 |
| rst_n0 | input | 1 | Asynchronous active-low reset, domain 0 |
| rst_n1 | input | 1 | Asynchronous active-low reset, domain 1 |
| rst_n2 | input | 1 | Asynchronous active-low reset, domain 2 |
| adv0 | input | 1 | Advance request, domain 0 |
| adv1 | input | 1 | Advance request, domain 1 |
| adv2 | input | 1 | Advance request, domain 2 |
| inj0 | input | 1 | Fault-injection strobe, domain 0 |
| inj1 | input | 1 | Fault-injection strobe, domain 1 |
| inj2 | input | 1 | Fault-injection strobe, domain 2 |
| inj_val0 | input | W | Value forced into domain 0 |
| inj_val1 | input | W | Value forced into domain 1 |
| inj_val2 | input | W | Value forced into domain 2 |
| q0 | output | W | Count pins, domain 0 |
| q1 | output | W | Count pins, domain 1 |
| q2 | output | W | Count pins, domain 2 |
| oe0 | output | 1 | Pad drive enable, domain 0 |
| oe1 | output | 1 | Pad drive enable, domain 1 |
| oe2 | output | 1 | Pad drive enable, domain 2 |
| err | output | 3 | Sticky disagreement flags, bit k for domain k |

## Verification
The bench builds the counter with W = 8, LIMIT = 200 and STEP = 7. With these values the count wraps about every 29 advances, so the random run crosses the modulo boundary many times. LIMIT is below 2**W, so injected values can fall outside the legal range and still be outvoted. The three clocks come from one source, which lets the bench model the board junction cycle by cycle. Single-domain injections land on every domain, sometimes on consecutive cycles across different domains, to show that each recovery takes exactly one edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_N = 3;

  // A copy stands alone when its two peers agree and it disagrees with them.
  function automatic logic is_dissent(input logic eq_peer_a, input logic eq_peer_b,
                                      input logic peers_agree);
    return peers_agree && !eq_peer_a && !eq_peer_b;
  endfunction
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] voted
);
  assign voted = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
endmodule

// File: rtl/tmr_dissent.sv
module tmr_dissent #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] own,
  input  logic [W-1:0] peer_a,
  input  logic [W-1:0] peer_b,
  output logic         drive_en
);
  import tmr_pkg::*;
  logic eq_a, eq_b, peers_eq;
  assign eq_a     = (own == peer_a);
  assign eq_b     = (own == peer_b);
  assign peers_eq = (peer_a == peer_b);
  assign drive_en = !is_dissent(eq_a, eq_b, peers_eq);
endmodule

// File: rtl/tmr_domain.sv
module tmr_domain #(
  parameter int unsigned W       = 8,
  parameter int unsigned LIMIT   = 200,
  parameter int unsigned STEP    = 7,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         inj,
  input  logic [W-1:0] inj_val,
  input  logic [W-1:0] peer_a,
  input  logic [W-1:0] peer_b,
  output logic [W-1:0] state,
  output logic         drive_en,
  output logic         flag
);
  localparam logic [W:0] LIM_X  = (W+1)'(LIMIT);
  localparam logic [W:0] STEP_X = (W+1)'(STEP);

  function automatic logic [W-1:0] advance(input logic [W-1:0] cur);
    logic [W:0] sum;
    sum = {1'b0, cur} + STEP_X;
    if (sum >= LIM_X) sum = sum - LIM_X;
    return sum[W-1:0];
  endfunction

  logic [W-1:0] voted, next_st;
  logic         mism;

  tmr_voter #(.W(W)) u_fb_vote (
    .in_a(state), .in_b(peer_a), .in_c(peer_b), .voted(voted)
  );

  assign next_st = adv ? advance(voted) : voted;
  assign mism    = (state != voted);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RST_VAL;
      flag  <= 1'b0;
    end else begin
      state <= inj ? inj_val : next_st;
      flag  <= flag | mism;
    end
  end

  tmr_dissent #(.W(W)) u_out_vote (
    .own(state), .peer_a(peer_a), .peer_b(peer_b), .drive_en(drive_en)
  );
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W     = 8,
  parameter int unsigned LIMIT = 200,
  parameter int unsigned STEP  = 7
) (
  input  logic         clk0,
  input  logic         clk1,
  input  logic         clk2,
  input  logic         rst_n0,
  input  logic         rst_n1,
  input  logic         rst_n2,
  input  logic         adv0,
  input  logic         adv1,
  input  logic         adv2,
  input  logic         inj0,
  input  logic         inj1,
  input  logic         inj2,
  input  logic [W-1:0] inj_val0,
  input  logic [W-1:0] inj_val1,
  input  logic [W-1:0] inj_val2,
  output logic [W-1:0] q0,
  output logic [W-1:0] q1,
  output logic [W-1:0] q2,
  output logic         oe0,
  output logic         oe1,
  output logic         oe2,
  output logic [2:0]   err
);
  import tmr_pkg::*;

  logic [TMR_N-1:0] clk_v, rst_v, adv_v, inj_v, oe_v;
  logic [W-1:0]     ival_v [TMR_N];
  logic [W-1:0]     st_v   [TMR_N];

  assign clk_v = {clk2, clk1, clk0};
  assign rst_v = {rst_n2, rst_n1, rst_n0};
  assign adv_v = {adv2, adv1, adv0};
  assign inj_v = {inj2, inj1, inj0};
  assign ival_v[0] = inj_val0;
  assign ival_v[1] = inj_val1;
  assign ival_v[2] = inj_val2;

  for (genvar k = 0; k < TMR_N; k++) begin : g_dom
    tmr_domain #(.W(W), .LIMIT(LIMIT), .STEP(STEP)) u_dom (
      .clk     (clk_v[k]),
      .rst_n   (rst_v[k]),
      .adv     (adv_v[k]),
      .inj     (inj_v[k]),
      .inj_val (ival_v[k]),
      .peer_a  (st_v[(k+1)%TMR_N]),
      .peer_b  (st_v[(k+2)%TMR_N]),
      .state   (st_v[k]),
      .drive_en(oe_v[k]),
      .flag    (err[k])
    );
  end

  assign q0  = st_v[0];
  assign q1  = st_v[1];
  assign q2  = st_v[2];
  assign oe0 = oe_v[0];
  assign oe1 = oe_v[1];
  assign oe2 = oe_v[2];
endmodule

// File: rtl/tmr_counter_chk.sv
module tmr_counter_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned LIMIT = 200,
  parameter int unsigned STEP  = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         adv0, adv1, adv2,
  input logic         inj0, inj1, inj2,
  input logic [W-1:0] q0, q1, q2,
  input logic         oe0,
  input logic [2:0]   err
);
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] v);
    int unsigned s;
    s = (int'(v) + STEP) % LIMIT;
    return W'(s);
  endfunction

  logic quiet, all_adv, none_adv, agree;
  assign quiet    = !inj0 && !inj1 && !inj2;
  assign all_adv  = adv0 && adv1 && adv2;
  assign none_adv = !adv0 && !adv1 && !adv2;
  assign agree    = (q0 == q1) && (q1 == q2);

  a_r5_realign: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && (all_adv || none_adv)) |=> (q0 == q1 && q1 == q2));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && all_adv && agree && q0 < W'(LIMIT)) |=> (q0 == wrap_add($past(q0))));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && none_adv && agree) |=> $stable(q0));

  a_r6_dissent: assert property (@(posedge clk) disable iff (!rst_n)
    !oe0 |-> (q0 != q1 && q0 != q2));

  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    (q1 == q2 && q0 != q1) |=> err[0]);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err[0] |=> err[0]);
endmodule

bind tmr_counter tmr_counter_chk #(.W(W), .LIMIT(LIMIT), .STEP(STEP)) u_chk (
  .clk(clk0), .rst_n(rst_n0),
  .adv0(adv0), .adv1(adv1), .adv2(adv2),
  .inj0(inj0), .inj1(inj1), .inj2(inj2),
  .q0(q0), .q1(q1), .q2(q2), .oe0(oe0), .err(err)
);

// File: tb/tb_tmr_counter.sv
module tb_tmr_counter;
  localparam int W = 8, LIMIT = 200, STEP = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] adv_v = '0, inj_v = '0;
  logic [W-1:0] iv0 = '0, iv1 = '0, iv2 = '0;
  logic [W-1:0] q0, q1, q2;
  logic oe0, oe1, oe2;
  logic [2:0] err;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_counter #(.W(W), .LIMIT(LIMIT), .STEP(STEP)) dut (
    .clk0(clk), .clk1(clk), .clk2(clk),
    .rst_n0(rst_n), .rst_n1(rst_n), .rst_n2(rst_n),
    .adv0(adv_v[0]), .adv1(adv_v[1]), .adv2(adv_v[2]),
    .inj0(inj_v[0]), .inj1(inj_v[1]), .inj2(inj_v[2]),
    .inj_val0(iv0), .inj_val1(iv1), .inj_val2(iv2),
    .q0(q0), .q1(q1), .q2(q2), .oe0(oe0), .oe1(oe1), .oe2(oe2), .err(err)
  );

  // golden single-counter model
  int g = 0;
  logic [2:0] errx = '0, pend = '0;
  int prev_dom = -1;

  function automatic int ref_next(input int v);
    int t;
    t = v + STEP;
    return (t >= LIMIT) ? t - LIMIT : t;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] qsel(input int k);
    return (k == 0) ? q0 : (k == 1) ? q1 : q2;
  endfunction

  function automatic logic oesel(input int k);
    return (k == 0) ? oe0 : (k == 1) ? oe1 : oe2;
  endfunction

  // board junction: bitwise wired resolution of enabled groups
  task automatic junction(output logic [W-1:0] val, output bit ok);
    ok = 1;
    val = '0;
    for (int b = 0; b < W; b++) begin
      bit h1, h0;
      h1 = 0; h0 = 0;
      for (int k = 0; k < 3; k++)
        if (oesel(k)) begin
          if (qsel(k)[b]) h1 = 1; else h0 = 1;
        end
      if (h1 == h0) ok = 0;
      val[b] = h1;
    end
  endtask

  task automatic step(input logic a, input int dom, input logic [W-1:0] v, input string tag);
    int qx [3];
    bit wrapped, jok;
    logic [W-1:0] jv;
    @(negedge clk);
    adv_v = {a, a, a};
    inj_v = '0;
    iv0 = v; iv1 = v; iv2 = v;
    if (dom >= 0) inj_v[dom] = 1'b1;
    @(posedge clk);
    #2;
    inj_v = '0;
    errx = errx | pend;
    wrapped = a && (g + STEP >= LIMIT);
    if (a) g = ref_next(g);
    pend = '0;
    for (int k = 0; k < 3; k++) qx[k] = (k == dom) ? int'(v) : g;
    if (dom >= 0 && int'(v) != g) pend[dom] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      string rq;
      if (k == prev_dom && k != dom) rq = "R5";
      else if (!a) rq = "R4";
      else if (wrapped) rq = "R3";
      else rq = "R2";
      chk(int'(qsel(k)) == qx[k], rq, int'(qsel(k)), qx[k]);
      chk(oesel(k) == (qx[k] == g), (tag != "") ? tag : "R6", int'(oesel(k)), int'(qx[k] == g));
    end
    junction(jv, jok);
    chk(jok && int'(jv) == g, "R7", int'(jv), g);
    chk(err == errx, (tag != "") ? tag : "R8", int'(err), int'(errx));
    prev_dom = dom;
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(q0 == 0 && q1 == 0 && q2 == 0, req, int'(q0), 0);
    chk(oe0 && oe1 && oe2, req, int'({oe2, oe1, oe0}), 7);
    chk(err == 3'b000, req, int'(err), 0);
    g = 0; errx = '0; pend = '0; prev_dom = -1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset("R1");
    // hold and plain advance
    step(1'b0, -1, '0, "");
    for (int i = 0; i < 40; i++) step(1'b1, -1, '0, "");
    // inject the correct value: no dissent, no flag
    step(1'b1, 1, W'(ref_next(g)), "R9");
    step(1'b1, -1, '0, "R9");
    // a fault on each domain, then one on consecutive cycles across domains
    for (int k = 0; k < 3; k++) begin
      step(1'b1, k, W'(8'hFF), "");
      step(1'b0, -1, '0, "");
    end
    step(1'b1, 0, W'(8'h55), "");
    step(1'b1, 2, W'(8'hAA), "");
    step(1'b1, -1, '0, "");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic a;
      int d;
      a = ($urandom % 4) != 0;
      d = (($urandom % 6) == 0) ? int'($urandom % 3) : -1;
      step(a, d, W'($urandom), "");
    end
    // reset clears flags and count
    chk(err != 3'b000, "R8", int'(err), 1);
    do_reset("R10");
    step(1'b1, -1, '0, "");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule